// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of trace frames into an internal ring memory while capture is on, so that the most recent history around an event of interest stays available. A trigger pulse from the trace source starts a programmable post-trigger count. Once that many further frames have been stored, acquisition stops by itself. Host software then uses the status flags and the write pointer to find the oldest valid frame and drains the memory through an auto-advancing data register.

Incoming frames first pass through a small drain queue, which stands in for the formatter, and are then written to the ring. The host sees nine 32-bit registers on a simple synchronous bus with select, write enable, address, write data and combinational read data. The registers are: identification, ring depth, frame width, status, frame data, read pointer, write pointer, post-trigger count and control. Both pointers wrap modulo the ring depth, which must be a power of two.

Top module: `trace_ring_capture`

## Requirements
- R1: Address map: 0 identification (ID_VALUE), 1 ring depth (DEPTH), 2 frame width (FRM_W), 3 status, 4 frame data, 5 read pointer, 6 write pointer, 7 post-trigger count, 8 control. Addresses 9 to 15 read 0. Reads are combinational in the same cycle as the address.
- R2: Control bit 0 turns capture on while set. Control bit 1 holds the port mode flag. Both read back at address 8, and writes take effect at the next clock edge.
- R3: Each frame accepted while capture is on is stored at the write pointer, and the pointer then advances by one modulo DEPTH. The stored word and the new pointer are visible two edges after the frame's cycle.
- R4: Status bit 0 (full) is set when a store lands in slot DEPTH-1. It stays set until capture is re-enabled.
- R5: Status bit 1 (triggered) is set at the edge after a trigger pulse arrives while capture is on.
- R6: After the trigger, each accepted frame decrements the post-trigger count. A frame that arrives in the same cycle as the trigger is stored but not counted. When the count is zero after the trigger, no more frames are accepted, and status bit 2 (complete) is set at the next edge. A count of N therefore stores exactly N frames after the trigger frame.
- R7: Status bit 3 (drained) is 1 when the drain queue holds no frames. It is 0 for the one cycle a frame spends in the queue.
- R8: A read of address 4 returns the word at the read pointer, and the pointer advances by one modulo DEPTH at that edge. Reads of other addresses and writes to address 4 leave the read pointer unchanged.
- R9: Writing address 5 or 6 loads that pointer with the written value modulo DEPTH. A pointer write wins over a same-cycle advance.
- R10: Frames are ignored while capture is off. Writing control bit 0 as 1 while capture is off clears the full, triggered and complete bits.
- R11: The post-trigger count register accepts and returns all 32 bits, for example a value of DEPTH times a percentage divided by 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | A trace frame is present this cycle |
| frm_word | input | FRM_W | Trace frame contents |
| trig_in | input | 1 | Trigger pulse from the trace source |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |

## Verification
Register reads are due in the same cycle as the address, and register writes are due one edge later. A frame reaches the ring and the write pointer two edges after its cycle, and the drained flag falls for exactly the one cycle in between. The complete flag rises one edge after the count reaches zero. A behavioural model in the bench advances on every rising edge and predicts read data for whatever address is on the bus. The bench compares the design against that prediction 1 ns after every falling edge, so each result is sampled once all of its registers have settled. Directed reads at the same sampling point check the status and pointer values worked out by hand for the wrap, zero-count and priority cases.

// File: rtl/trc_pkg.sv
package trc_pkg;
   localparam int REG_W = 32;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_IDENT  = 4'd0,
      RA_DEPTH  = 4'd1,
      RA_WIDTH  = 4'd2,
      RA_STATUS = 4'd3,
      RA_DATA   = 4'd4,
      RA_RDPTR  = 4'd5,
      RA_WRPTR  = 4'd6,
      RA_TRGCNT = 4'd7,
      RA_CTRL   = 4'd8
   } reg_addr_e;

   localparam int CT_EN    = 0;
   localparam int CT_DEMUX = 1;

   typedef struct packed {
      logic drained;
      logic complete;
      logic triggered;
      logic full;
   } status_t;
endpackage

// File: rtl/trc_drain_fifo.sv
module trc_drain_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad
         $error("trc_drain_fifo: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_slot
         logic [W-1:0] hold_q;
         logic         busy_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    busy_q <= 1'b0;
            else if (push) busy_q <= 1'b1;
            else if (pop)  busy_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (push) hold_q <= din;
         end

         assign dout  = hold_q;
         assign empty = !busy_q;
         assign full  = busy_q;
      end else begin : g_ring
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] hd_q, tl_q;
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hd_q  <= '0;
               tl_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push) tl_q <= (tl_q == AW'(DEPTH - 1)) ? '0 : tl_q + 1'b1;
               if (pop)  hd_q <= (hd_q == AW'(DEPTH - 1)) ? '0 : hd_q + 1'b1;
               cnt_q <= cnt_q + CW'(push) - CW'(pop);
            end
         end

         always_ff @(posedge clk) begin
            if (push) mem[tl_q] <= din;
         end

         assign dout  = mem[hd_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CW'(DEPTH));
      end
   endgenerate

   // R7: the queue never takes a frame it has no room for
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push && full |-> pop);
   // R7: the queue never releases a frame it does not hold
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/trc_ring_store.sv
module trc_ring_store #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_we,
   input  logic [W-1:0]  st_data,
   input  logic          rd_step,
   input  logic          wp_ld,
   input  logic          rp_ld,
   input  logic [PW-1:0] ld_val,
   input  logic          full_clr,
   output logic [PW-1:0] wptr,
   output logic [PW-1:0] rptr,
   output logic [W-1:0]  rd_data,
   output logic          full
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [W-1:0] ring [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wptr <= '0;
      else if (wp_ld) wptr <= ld_val;
      else if (st_we) wptr <= wptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rptr <= '0;
      else if (rp_ld)   rptr <= ld_val;
      else if (rd_step) rptr <= rptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        full <= 1'b0;
      else if (full_clr)                 full <= 1'b0;
      else if (st_we && (wptr == LAST))  full <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (st_we) ring[wptr] <= st_data;
   end

   assign rd_data = ring[rptr];

   // R8: a data read moves the read pointer on by exactly one slot
   a_r8_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_step && !rp_ld |=> rptr == PW'($past(rptr) + 1'b1));
   // R3: without a store or a load the write pointer holds
   a_r3_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !st_we && !wp_ld |=> $stable(wptr));
   // R4: once set, full only leaves on a restart
   a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      full && !full_clr |=> full);
endmodule

// File: rtl/trc_acq_ctrl.sv
module trc_acq_ctrl #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [1:0]       ctrl_wdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             trig_in,
   input  logic             frm_valid,
   output logic             en,
   output logic             demux,
   output logic             trig_seen,
   output logic             done,
   output logic [CNT_W-1:0] tcnt,
   output logic             accept,
   output logic             en_rise
);
   import trc_pkg::*;

   logic cnt_zero;

   assign cnt_zero = (tcnt == '0);
   assign en_rise  = ctrl_we && ctrl_wdata[CT_EN] && !en;
   assign accept   = en && frm_valid && !done && !(trig_seen && cnt_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b0;
         demux <= 1'b0;
      end else if (ctrl_we) begin
         en    <= ctrl_wdata[CT_EN];
         demux <= ctrl_wdata[CT_DEMUX];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              trig_seen <= 1'b0;
      else if (en_rise)        trig_seen <= 1'b0;
      else if (en && trig_in)  trig_seen <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              done <= 1'b0;
      else if (en_rise)                        done <= 1'b0;
      else if (en && trig_seen && cnt_zero)    done <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      tcnt <= '0;
      else if (cnt_we)                 tcnt <= cnt_wdata;
      else if (accept && trig_seen)    tcnt <= tcnt - 1'b1;
   end

   // R5: the trigger flag is held until a restart
   a_r5_trig_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      trig_seen && !en_rise |=> trig_seen);
   // R6: every counted frame takes exactly one off the count
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      trig_seen && accept && !cnt_we |=> tcnt == $past(tcnt) - 1'b1);
   // R10: a restart leaves trigger and completion clear
   a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> !trig_seen && !done);
endmodule

// File: rtl/trace_ring_capture.sv
module trace_ring_capture #(
   parameter int          DEPTH     = 16,
   parameter int          FRM_W     = 32,
   parameter int          FMT_DEPTH = 2,
   parameter logic [31:0] ID_VALUE  = 32'h5452_0001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_valid,
   input  logic [FRM_W-1:0] frm_word,
   input  logic             trig_in,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [3:0]       bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata
);
   import trc_pkg::*;

   localparam int PW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("trace_ring_capture: DEPTH must be a power of two, at least 2");
      end
      if (FRM_W < 1 || FRM_W > REG_W) begin : g_bad_width
         $error("trace_ring_capture: FRM_W must lie in 1..32");
      end
   endgenerate

   logic wr_acc, rd_acc;
   logic ctrl_we, cnt_we, wp_ld, rp_ld, rd_step;
   logic en, demux, trig_seen, done, accept, en_rise;
   logic [REG_W-1:0] tcnt;
   logic [FRM_W-1:0] q_word, rd_word;
   logic q_empty, q_full;
   logic [PW-1:0] wptr, rptr;
   logic full;
   status_t stat;

   assign wr_acc  = bus_sel && bus_we;
   assign rd_acc  = bus_sel && !bus_we;
   assign ctrl_we = wr_acc && (bus_addr == RA_CTRL);
   assign cnt_we  = wr_acc && (bus_addr == RA_TRGCNT);
   assign wp_ld   = wr_acc && (bus_addr == RA_WRPTR);
   assign rp_ld   = wr_acc && (bus_addr == RA_RDPTR);
   assign rd_step = rd_acc && (bus_addr == RA_DATA);

   trc_acq_ctrl #(.CNT_W(REG_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (bus_wdata[1:0]),
      .cnt_we     (cnt_we),
      .cnt_wdata  (bus_wdata),
      .trig_in    (trig_in),
      .frm_valid  (frm_valid),
      .en         (en),
      .demux      (demux),
      .trig_seen  (trig_seen),
      .done       (done),
      .tcnt       (tcnt),
      .accept     (accept),
      .en_rise    (en_rise)
   );

   trc_drain_fifo #(.W(FRM_W), .DEPTH(FMT_DEPTH)) u_fmt (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .din   (frm_word),
      .pop   (!q_empty),
      .dout  (q_word),
      .empty (q_empty),
      .full  (q_full)
   );

   trc_ring_store #(.W(FRM_W), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .st_we    (!q_empty),
      .st_data  (q_word),
      .rd_step  (rd_step),
      .wp_ld    (wp_ld),
      .rp_ld    (rp_ld),
      .ld_val   (bus_wdata[PW-1:0]),
      .full_clr (en_rise),
      .wptr     (wptr),
      .rptr     (rptr),
      .rd_data  (rd_word),
      .full     (full)
   );

   assign stat = '{drained: q_empty, complete: done, triggered: trig_seen, full: full};

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_IDENT:  bus_rdata = ID_VALUE;
         RA_DEPTH:  bus_rdata = REG_W'(DEPTH);
         RA_WIDTH:  bus_rdata = REG_W'(FRM_W);
         RA_STATUS: bus_rdata = REG_W'(stat);
         RA_DATA:   bus_rdata = REG_W'(rd_word);
         RA_RDPTR:  bus_rdata = REG_W'(rptr);
         RA_WRPTR:  bus_rdata = REG_W'(wptr);
         RA_TRGCNT: bus_rdata = tcnt;
         RA_CTRL:   bus_rdata = REG_W'({demux, en});
         default:   bus_rdata = '0;
      endcase
   end

   // R6: after completion with the queue drained, the ring is frozen
   a_r6_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done && q_empty && !wp_ld |=> $stable(wptr));
   // R10: with capture off nothing enters the queue
   a_r10_off_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      !en && q_empty |=> q_empty);
   // R7: the queue depth is never reached with one pop per cycle
   a_r7_queue_room: assert property (@(posedge clk) disable iff (!rst_n)
      (FMT_DEPTH > 1) |-> !q_full);
endmodule

// File: tb/tb_trace_ring_capture.sv
`timescale 1ns/100ps
module tb_trace_ring_capture;
   localparam int DEPTH = 16;
   localparam logic [31:0] IDV = 32'h5452_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frm_valid = 1'b0;
   logic [31:0] frm_word = '0;
   logic trig_in = 1'b0;
   logic bus_sel = 1'b0;
   logic bus_we = 1'b0;
   logic [3:0] bus_addr = 4'd3;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int nvec = 0;
   int nfail = 0;
   int fseq = 0;

   always #2.5 clk = ~clk;

   trace_ring_capture #(.DEPTH(DEPTH), .FRM_W(32), .FMT_DEPTH(2), .ID_VALUE(IDV)) dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_word(frm_word),
      .trig_in(trig_in), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   // behavioural reference model
   logic [31:0] m_ram [DEPTH];
   bit          m_ok  [DEPTH];
   logic [31:0] m_q [$];
   int m_wp, m_rp;
   bit m_full, m_trig, m_done, m_en, m_demux;
   logic [31:0] m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wp = 0; m_rp = 0; m_full = 0; m_trig = 0; m_done = 0;
         m_en = 0; m_demux = 0; m_cnt = '0; m_q.delete();
         for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;
      end else begin
         bit wr, rd, rise, acc, popped;
         logic [31:0] pw;
         int nwp, nrp;
         bit nfull, ntrig, ndone;
         logic [31:0] ncnt;
         wr = bus_sel && bus_we;
         rd = bus_sel && !bus_we;
         rise = wr && bus_addr == 8 && bus_wdata[0] && !m_en;
         acc = m_en && frm_valid && !m_done && !(m_trig && m_cnt == 0);
         popped = m_q.size() > 0;
         pw = popped ? m_q[0] : '0;
         nfull = rise ? 1'b0 : ((popped && m_wp == DEPTH - 1) ? 1'b1 : m_full);
         nwp = (wr && bus_addr == 6) ? int'(bus_wdata % DEPTH) :
               (popped ? (m_wp + 1) % DEPTH : m_wp);
         nrp = (wr && bus_addr == 5) ? int'(bus_wdata % DEPTH) :
               ((rd && bus_addr == 4) ? (m_rp + 1) % DEPTH : m_rp);
         ntrig = rise ? 1'b0 : ((m_en && trig_in) ? 1'b1 : m_trig);
         ndone = rise ? 1'b0 : ((m_en && m_trig && m_cnt == 0) ? 1'b1 : m_done);
         ncnt = (wr && bus_addr == 7) ? bus_wdata : ((acc && m_trig) ? m_cnt - 1 : m_cnt);
         if (popped) begin
            m_ram[m_wp] = pw; m_ok[m_wp] = 1;
            void'(m_q.pop_front());
         end
         if (acc) m_q.push_back(frm_word);
         if (wr && bus_addr == 8) begin m_en = bus_wdata[0]; m_demux = bus_wdata[1]; end
         m_wp = nwp; m_rp = nrp; m_full = nfull; m_trig = ntrig; m_done = ndone; m_cnt = ncnt;
      end
   end

   function automatic logic [31:0] exp_rd(input logic [3:0] a);
      case (a)
         4'd0: return IDV;
         4'd1: return 32'(DEPTH);
         4'd2: return 32'd32;
         4'd3: return {28'd0, m_q.size() == 0, m_done, m_trig, m_full};
         4'd4: return m_ram[m_rp];
         4'd5: return 32'(m_rp);
         4'd6: return 32'(m_wp);
         4'd7: return m_cnt;
         4'd8: return {30'd0, m_demux, m_en};
         default: return '0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] a);
      case (a)
         4'd0, 4'd1, 4'd2: return "R1";
         4'd3: return "R4";
         4'd4, 4'd5: return "R8";
         4'd6: return "R3";
         4'd7: return "R6";
         4'd8: return "R2";
         default: return "R1";
      endcase
   endfunction

   // every-cycle comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (rst_n && !(bus_addr == 4 && !m_ok[m_rp])) begin
         nvec++;
         if (bus_rdata !== exp_rd(bus_addr)) begin
            nfail++;
            $display("FAIL %s per-cycle addr %0d: actual %h expected %h",
                     req_of(bus_addr), bus_addr, bus_rdata, exp_rd(bus_addr));
         end
      end
   end

   task automatic drive(input bit s, input bit w, input logic [3:0] a,
                        input logic [31:0] d, input bit fv, input bit tr);
      @(negedge clk);
      bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
      frm_valid = fv; trig_in = tr;
      if (fv) begin fseq++; frm_word = 32'hA500_0000 + 32'(fseq); end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      drive(1, 1, a, d, 0, 0);
   endtask

   task automatic frames(input int n, input bit trig_first);
      for (int i = 0; i < n; i++) drive(0, 0, 4'd3, '0, 1, trig_first && i == 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 4'd3, '0, 0, 0);
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
      drive(1, 0, a, '0, 0, 0);
      #1;
      nvec++;
      if (bus_rdata !== exp) begin
         nfail++;
         $display("FAIL %s addr %0d: actual %h expected %h", req, a, bus_rdata, exp);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      int pct_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state and constant registers (R1, R7)
      rd_chk(4'd3, 32'h8, "R7");
      rd_chk(4'd0, IDV, "R1");
      rd_chk(4'd1, 32'(DEPTH), "R1");
      rd_chk(4'd2, 32'd32, "R1");
      rd_chk(4'd9, 32'd0, "R1");
      // R11 full-width count, R2 mode flag without enable
      wr_reg(4'd7, 32'hDEAD_BEEF);
      rd_chk(4'd7, 32'hDEAD_BEEF, "R11");
      wr_reg(4'd8, 32'h2);
      rd_chk(4'd8, 32'h2, "R2");
      // R10: frames ignored while capture is off
      frames(3, 1);
      idle(2);
      rd_chk(4'd6, 32'd0, "R10");
      rd_chk(4'd3, 32'h8, "R10");
      // capture with half the ring after the trigger
      pct_cnt = DEPTH * 50 / 100;
      wr_reg(4'd7, 32'(pct_cnt));
      wr_reg(4'd6, 32'd0);
      wr_reg(4'd8, 32'h1);
      frames(5, 0);
      frames(1, 1);
      rd_chk(4'd3, 32'h2, "R7");
      frames(pct_cnt + 6, 0);
      idle(3);
      rd_chk(4'd3, 32'hE, "R6");
      rd_chk(4'd6, 32'd14, "R3");
      // drain (R8), then reads elsewhere must not move the read pointer
      wr_reg(4'd5, 32'd0);
      for (int i = 0; i < 14; i++) drive(1, 0, 4'd4, '0, 0, 0);
      rd_chk(4'd3, 32'hE, "R8");
      wr_reg(4'd4, 32'h1234);
      rd_chk(4'd5, 32'd14, "R8");
      // restart clears flags, then wrap from slot 10 (R4, R9, R10)
      wr_reg(4'd8, 32'h0);
      wr_reg(4'd8, 32'h1);
      rd_chk(4'd3, 32'h8, "R10");
      wr_reg(4'd7, 32'd3);
      wr_reg(4'd6, 32'd26);
      rd_chk(4'd6, 32'd10, "R9");
      frames(12, 0);
      idle(2);
      rd_chk(4'd3, 32'h9, "R4");
      rd_chk(4'd6, 32'd6, "R4");
      frames(1, 1);
      frames(5, 0);
      idle(3);
      rd_chk(4'd3, 32'hF, "R6");
      rd_chk(4'd6, 32'd10, "R6");
      wr_reg(4'd5, 32'd10);
      for (int i = 0; i < DEPTH; i++) drive(1, 0, 4'd4, '0, 0, 0);
      rd_chk(4'd5, 32'd10, "R8");
      // zero post-trigger count: only the trigger frame is kept
      wr_reg(4'd8, 32'h0);
      wr_reg(4'd8, 32'h3);
      wr_reg(4'd7, 32'd0);
      wr_reg(4'd6, 32'd0);
      frames(1, 1);
      frames(4, 0);
      idle(3);
      rd_chk(4'd3, 32'hE, "R6");
      rd_chk(4'd6, 32'd1, "R6");
      rd_chk(4'd8, 32'h3, "R2");
      // pointer load beats a same-cycle store (R9)
      wr_reg(4'd8, 32'h0);
      wr_reg(4'd8, 32'h1);
      wr_reg(4'd7, 32'd5);
      frames(1, 0);
      wr_reg(4'd6, 32'd3);
      idle(1);
      rd_chk(4'd6, 32'd3, "R9");
      wr_reg(4'd5, 32'd1);
      rd_chk(4'd4, 32'hA500_0000 + 32'(fseq), "R3");
      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule